// File: doc/BRIEF.md
# Prescaled Conversion-Trigger Pulse Generator

This block turns timer events from a PWM channel into start-of-conversion strobes for an analog-to-digital converter. A 3-bit select code picks one event source: counter-at-zero, counter-at-period, either of those, one of the up-count or down-count compare matches, or a digital-compare conversion trigger. A bank bit swaps the A and B compare matches for the C and D matches. A software force strobe counts as one extra event. The block counts the selected events and emits a single-cycle pulse on every Nth one.

Two prescalers are available, and a mode bit picks one of them. The short prescaler has a 2-bit counter and period. The long prescaler has a 4-bit counter and period, and its counter can be preloaded from an init value on a sync pulse or on a software force. A sticky flag records that a pulse was issued, and pulses keep coming while the flag is set. The enable gates only the pulse. Counting continues while the block is disabled, so the next event after re-enable can fire at once.

Top module: `soc_trig_gen`

## Requirements
- R1: Each select code picks one source, and an event on any other source produces no pulse. The codes are: 000 digital-compare trigger, 001 counter-at-zero, 010 counter-at-period, 011 zero or period, 100 up-count match A, 101 down-count match A, 110 up-count match B, 111 down-count match B. When `cmp_bank` is 1, codes 100 to 111 use match C in place of A and match D in place of B.
- R2: A high `force_evt` in a cycle counts as one selected event.
- R3: With enable high and period P > 0, the Kth counted event after the counter is at zero produces `soc_pulse` high for exactly the clock cycle after the event when K mod P = 0. At that same edge the counter returns to 0. Otherwise the counter reads K mod P.
- R4: `long_mode` = 0 counts with the 2-bit counter and `short_prd`. `long_mode` = 1 counts with the 4-bit counter and `long_prd`. The counter that is not selected holds its value.
- R5: An active period of 0 stops counting. No pulse is issued, and forced events are ignored.
- R6: While `en` is 0, no pulse is issued. Events still advance the counter up to the period, and it then holds there. After re-enable, the next event produces a pulse and the counter returns to 0.
- R7: `flag` goes high on the same edge as each pulse and stays high. Further pulses are still produced while it is set.
- R8: `flag_clr` resets only `flag`, and leaves the counters unchanged. If a pulse is issued in the same cycle, the flag stays set.
- R9: When `init_en` is 1, a `sync_in` or `init_force` strobe loads `init_val` into the 4-bit counter. That load overrides any event in the same cycle and produces no pulse. When `init_en` is 0, these strobes have no effect.
- R10: After a synchronous reset, `soc_pulse`, `flag` and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_zero | input | 1 | Timer counter equals zero |
| ev_period | input | 1 | Timer counter equals period |
| ev_up_a | input | 1 | Compare A match while counting up |
| ev_dn_a | input | 1 | Compare A match while counting down |
| ev_up_b | input | 1 | Compare B match while counting up |
| ev_dn_b | input | 1 | Compare B match while counting down |
| ev_up_c | input | 1 | Compare C match while counting up |
| ev_dn_c | input | 1 | Compare C match while counting down |
| ev_up_d | input | 1 | Compare D match while counting up |
| ev_dn_d | input | 1 | Compare D match while counting down |
| ev_dc | input | 1 | Digital-compare conversion trigger |
| en | input | 1 | Pulse output enable |
| sel | input | 3 | Event select code |
| cmp_bank | input | 1 | 1 selects compare matches C/D in place of A/B |
| long_mode | input | 1 | 1 selects the 4-bit prescaler |
| short_prd | input | SHORT_W | Short prescaler period |
| long_prd | input | LONG_W | Long prescaler period |
| init_en | input | 1 | Allows preload of the long counter |
| init_val | input | LONG_W | Preload value |
| sync_in | input | 1 | Sync strobe that triggers a preload |
| init_force | input | 1 | Software strobe that triggers a preload |
| force_evt | input | 1 | Software event strobe |
| flag_clr | input | 1 | Clears the sticky flag |
| soc_pulse | output | 1 | Conversion start pulse |
| flag | output | 1 | Sticky pulse-issued flag |
| short_cnt | output | SHORT_W | Short prescaler counter |
| long_cnt | output | LONG_W | Long prescaler counter |

## Verification
The bench builds the block with its default widths: a 2-bit short prescaler and a 4-bit long prescaler. These widths are small enough to sweep every non-zero period of both prescalers over two full wrap cycles each, and to try every pairing of select code, bank bit and single active source. On top of the sweeps, the bench directly checks a zero period, disabled counting with saturation at the period, flag set/clear priority, and preload with its override of a same-cycle event.

// File: rtl/soc_trig_pkg.sv
package soc_trig_pkg;

    typedef enum logic [2:0] {
        SEL_DC       = 3'd0,
        SEL_ZERO     = 3'd1,
        SEL_PRD      = 3'd2,
        SEL_ZERO_PRD = 3'd3,
        SEL_UP_AC    = 3'd4,
        SEL_DN_AC    = 3'd5,
        SEL_UP_BD    = 3'd6,
        SEL_DN_BD    = 3'd7
    } soc_sel_e;

    typedef struct packed {
        logic dc;
        logic dn_d;
        logic up_d;
        logic dn_c;
        logic up_c;
        logic dn_b;
        logic up_b;
        logic dn_a;
        logic up_a;
        logic period;
        logic zero;
    } soc_evt_t;

    // Returns the source chosen by the select code and compare bank
    function automatic logic pick_event(soc_evt_t ev, soc_sel_e s, logic bank);
        logic hit;
        unique case (s)
            SEL_DC:       hit = ev.dc;
            SEL_ZERO:     hit = ev.zero;
            SEL_PRD:      hit = ev.period;
            SEL_ZERO_PRD: hit = ev.zero | ev.period;
            SEL_UP_AC:    hit = bank ? ev.up_c : ev.up_a;
            SEL_DN_AC:    hit = bank ? ev.dn_c : ev.dn_a;
            SEL_UP_BD:    hit = bank ? ev.up_d : ev.up_b;
            SEL_DN_BD:    hit = bank ? ev.dn_d : ev.dn_b;
            default:      hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/soc_evt_sel.sv
module soc_evt_sel
    import soc_trig_pkg::*;
(
    input  soc_evt_t   ev,
    input  logic [2:0] sel,
    input  logic       cmp_bank,
    input  logic       force_evt,
    output logic       evt
);
    soc_sel_e sel_e;

    always_comb begin
        sel_e = soc_sel_e'(sel);
        evt   = pick_event(ev, sel_e, cmp_bank) | force_evt;
    end
endmodule

// File: rtl/soc_presc_cnt.sv
module soc_presc_cnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         en,
    input  logic         evt,
    input  logic [W-1:0] prd,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         fire
);
    logic [W:0]   inc;
    logic         counting;
    logic         reach;
    logic [W-1:0] cnt_nxt;

    always_comb begin
        inc      = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
        counting = active && evt && (prd != '0) && !load;
        reach    = inc >= {1'b0, prd};
        fire     = counting && en && reach;
        cnt_nxt  = cnt;
        if (load) begin
            cnt_nxt = load_val;
        end else if (counting) begin
            if (en) begin
                cnt_nxt = reach ? '0 : inc[W-1:0];
            end else if (cnt < prd) begin
                cnt_nxt = inc[W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_nxt;
    end
endmodule

// File: rtl/soc_trig_gen.sv
module soc_trig_gen
    import soc_trig_pkg::*;
#(
    parameter int SHORT_W = 2,
    parameter int LONG_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ev_zero,
    input  logic               ev_period,
    input  logic               ev_up_a,
    input  logic               ev_dn_a,
    input  logic               ev_up_b,
    input  logic               ev_dn_b,
    input  logic               ev_up_c,
    input  logic               ev_dn_c,
    input  logic               ev_up_d,
    input  logic               ev_dn_d,
    input  logic               ev_dc,
    input  logic               en,
    input  logic [2:0]         sel,
    input  logic               cmp_bank,
    input  logic               long_mode,
    input  logic [SHORT_W-1:0] short_prd,
    input  logic [LONG_W-1:0]  long_prd,
    input  logic               init_en,
    input  logic [LONG_W-1:0]  init_val,
    input  logic               sync_in,
    input  logic               init_force,
    input  logic               force_evt,
    input  logic               flag_clr,
    output logic               soc_pulse,
    output logic               flag,
    output logic [SHORT_W-1:0] short_cnt,
    output logic [LONG_W-1:0]  long_cnt
);
    soc_evt_t ev;
    logic     evt;
    logic     preload;
    logic     fire_s;
    logic     fire_l;
    logic     fire;

    always_comb begin
        ev.zero   = ev_zero;
        ev.period = ev_period;
        ev.up_a   = ev_up_a;
        ev.dn_a   = ev_dn_a;
        ev.up_b   = ev_up_b;
        ev.dn_b   = ev_dn_b;
        ev.up_c   = ev_up_c;
        ev.dn_c   = ev_dn_c;
        ev.up_d   = ev_up_d;
        ev.dn_d   = ev_dn_d;
        ev.dc     = ev_dc;
        preload   = init_en && (sync_in || init_force);
        fire      = fire_s | fire_l;
    end

    soc_evt_sel u_sel (
        .ev        (ev),
        .sel       (sel),
        .cmp_bank  (cmp_bank),
        .force_evt (force_evt),
        .evt       (evt)
    );

    soc_presc_cnt #(.W(SHORT_W)) u_short (
        .clk      (clk),
        .rst      (rst),
        .active   (!long_mode),
        .en       (en),
        .evt      (evt),
        .prd      (short_prd),
        .load     (1'b0),
        .load_val ({SHORT_W{1'b0}}),
        .cnt      (short_cnt),
        .fire     (fire_s)
    );

    soc_presc_cnt #(.W(LONG_W)) u_long (
        .clk      (clk),
        .rst      (rst),
        .active   (long_mode),
        .en       (en),
        .evt      (evt),
        .prd      (long_prd),
        .load     (preload),
        .load_val (init_val),
        .cnt      (long_cnt),
        .fire     (fire_l)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            soc_pulse <= 1'b0;
            flag      <= 1'b0;
        end else begin
            soc_pulse <= fire;
            flag      <= fire | (flag & ~flag_clr);
        end
    end
endmodule

// File: rtl/soc_trig_chk.sv
module soc_trig_chk #(
    parameter int SHORT_W = 2,
    parameter int LONG_W  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               en,
    input logic               long_mode,
    input logic [SHORT_W-1:0] short_prd,
    input logic               init_en,
    input logic               sync_in,
    input logic               init_force,
    input logic [LONG_W-1:0]  init_val,
    input logic               flag_clr,
    input logic               soc_pulse,
    input logic               flag,
    input logic [SHORT_W-1:0] short_cnt,
    input logic [LONG_W-1:0]  long_cnt
);
    a_r7_pulse_sets_flag: assert property (@(posedge clk) disable iff (rst)
        soc_pulse |-> flag);

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        flag && !flag_clr |=> flag);

    a_r6_disabled_silent: assert property (@(posedge clk) disable iff (rst)
        !en |=> !soc_pulse);

    a_r5_zero_period_idle: assert property (@(posedge clk) disable iff (rst)
        !long_mode && short_prd == '0 |=> !soc_pulse && $stable(short_cnt));

    a_r4_long_holds: assert property (@(posedge clk) disable iff (rst)
        !long_mode && !(init_en && (sync_in || init_force)) |=> $stable(long_cnt));

    a_r4_short_holds: assert property (@(posedge clk) disable iff (rst)
        long_mode |=> $stable(short_cnt));

    a_r9_preload: assert property (@(posedge clk) disable iff (rst)
        init_en && (sync_in || init_force) |=> long_cnt == $past(init_val));
endmodule

bind soc_trig_gen soc_trig_chk #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .long_mode  (long_mode),
    .short_prd  (short_prd),
    .init_en    (init_en),
    .sync_in    (sync_in),
    .init_force (init_force),
    .init_val   (init_val),
    .flag_clr   (flag_clr),
    .soc_pulse  (soc_pulse),
    .flag       (flag),
    .short_cnt  (short_cnt),
    .long_cnt   (long_cnt)
);

// File: tb/test_soc_trig_gen.sv
module test_soc_trig_gen;
    localparam int SW = 2;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [10:0]   src = '0;
    logic          en = 1'b1;
    logic [2:0]    sel = 3'd0;
    logic          cmp_bank = 1'b0;
    logic          long_mode = 1'b0;
    logic [SW-1:0] short_prd = '0;
    logic [LW-1:0] long_prd = '0;
    logic          init_en = 1'b0;
    logic [LW-1:0] init_val = '0;
    logic          sync_in = 1'b0;
    logic          init_force = 1'b0;
    logic          force_evt = 1'b0;
    logic          flag_clr = 1'b0;
    logic          soc_pulse;
    logic          flag;
    logic [SW-1:0] short_cnt;
    logic [LW-1:0] long_cnt;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    soc_trig_gen #(.SHORT_W(SW), .LONG_W(LW)) i_soc_trig_gen (
        .clk(clk), .rst(rst),
        .ev_zero(src[0]), .ev_period(src[1]),
        .ev_up_a(src[2]), .ev_dn_a(src[3]), .ev_up_b(src[4]), .ev_dn_b(src[5]),
        .ev_up_c(src[6]), .ev_dn_c(src[7]), .ev_up_d(src[8]), .ev_dn_d(src[9]),
        .ev_dc(src[10]),
        .en(en), .sel(sel), .cmp_bank(cmp_bank), .long_mode(long_mode),
        .short_prd(short_prd), .long_prd(long_prd), .init_en(init_en),
        .init_val(init_val), .sync_in(sync_in), .init_force(init_force),
        .force_evt(force_evt), .flag_clr(flag_clr),
        .soc_pulse(soc_pulse), .flag(flag), .short_cnt(short_cnt), .long_cnt(long_cnt)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic pulse_force();
        force_evt = 1'b1;
        tick();
        force_evt = 1'b0;
    endtask

    function automatic int exp_hit(int code, int bank, int s);
        case (code)
            0: return int'(s == 10);
            1: return int'(s == 0);
            2: return int'(s == 1);
            3: return int'(s == 0 || s == 1);
            4: return int'(s == (bank ? 6 : 2));
            5: return int'(s == (bank ? 7 : 3));
            6: return int'(s == (bank ? 8 : 4));
            default: return int'(s == (bank ? 9 : 5));
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10 reset state
        chk("R10", "pulse", int'(soc_pulse), 0);
        chk("R10", "flag", int'(flag), 0);
        chk("R10", "short_cnt", int'(short_cnt), 0);
        chk("R10", "long_cnt", int'(long_cnt), 0);

        // R1 select sweep: every code, bank and single source with period 1
        short_prd = 2'd1;
        for (int c = 0; c < 8; c++) begin
            for (int b = 0; b < 2; b++) begin
                for (int s = 0; s < 11; s++) begin
                    sel = 3'(c);
                    cmp_bank = b[0];
                    src = 11'(1) << s;
                    tick();
                    src = '0;
                    chk("R1", $sformatf("sel%0d bank%0d src%0d", c, b, s),
                        int'(soc_pulse), exp_hit(c, b, s));
                end
            end
        end

        // R2/R3/R4/R7 prescale sweep with forced events, both modes
        sel = 3'd0;
        cmp_bank = 1'b0;
        for (int m = 0; m < 2; m++) begin
            for (int p = 1; p <= (m ? 15 : 3); p++) begin
                long_mode = m[0];
                short_prd = m ? 2'd3 : 2'(p);
                long_prd  = m ? 4'(p) : 4'd15;
                do_reset();
                for (int k = 1; k <= 2 * p + 1; k++) begin
                    pulse_force();
                    chk("R3", $sformatf("m%0d p%0d k%0d pulse", m, p, k),
                        int'(soc_pulse), int'(k % p == 0));
                    chk("R3", $sformatf("m%0d p%0d k%0d cnt", m, p, k),
                        m ? int'(long_cnt) : int'(short_cnt), k % p);
                    chk("R4", $sformatf("m%0d p%0d idle cnt", m, p),
                        m ? int'(short_cnt) : int'(long_cnt), 0);
                end
                chk("R7", "flag after pulses", int'(flag), 1);
                tick();
                chk("R3", "pulse one cycle", int'(soc_pulse), 0);
            end
        end

        // R5 zero period
        long_mode = 1'b0;
        short_prd = 2'd0;
        do_reset();
        for (int k = 0; k < 3; k++) begin
            pulse_force();
            chk("R5", "short pulse", int'(soc_pulse), 0);
            chk("R5", "short cnt", int'(short_cnt), 0);
        end
        long_mode = 1'b1;
        long_prd = 4'd0;
        pulse_force();
        chk("R5", "long pulse", int'(soc_pulse), 0);
        chk("R5", "long cnt", int'(long_cnt), 0);

        // R6 disabled counting saturates, re-enable fires on next event
        long_prd = 4'd3;
        en = 1'b0;
        do_reset();
        for (int k = 1; k <= 5; k++) begin
            pulse_force();
            chk("R6", "disabled pulse", int'(soc_pulse), 0);
            chk("R6", "disabled cnt", int'(long_cnt), (k < 3) ? k : 3);
        end
        en = 1'b1;
        pulse_force();
        chk("R6", "reenable pulse", int'(soc_pulse), 1);
        chk("R6", "reenable cnt", int'(long_cnt), 0);
        pulse_force();
        chk("R6", "after cnt", int'(long_cnt), 1);

        // R8 flag clear, counters untouched; set wins over clear
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
        chk("R8", "flag cleared", int'(flag), 0);
        chk("R8", "cnt kept", int'(long_cnt), 1);
        pulse_force();
        chk("R8", "cnt 2", int'(long_cnt), 2);
        flag_clr = 1'b1;
        force_evt = 1'b1;
        tick();
        flag_clr = 1'b0;
        force_evt = 1'b0;
        chk("R8", "set over clear pulse", int'(soc_pulse), 1);
        chk("R8", "set over clear flag", int'(flag), 1);

        // R9 preload
        long_prd = 4'd15;
        init_en = 1'b1;
        init_val = 4'd9;
        sync_in = 1'b1;
        tick();
        sync_in = 1'b0;
        chk("R9", "sync load", int'(long_cnt), 9);
        init_val = 4'd4;
        init_force = 1'b1;
        tick();
        init_force = 1'b0;
        chk("R9", "force load", int'(long_cnt), 4);
        init_en = 1'b0;
        init_val = 4'd11;
        sync_in = 1'b1;
        init_force = 1'b1;
        tick();
        sync_in = 1'b0;
        init_force = 1'b0;
        chk("R9", "load disabled", int'(long_cnt), 4);
        init_en = 1'b1;
        init_val = 4'd13;
        sync_in = 1'b1;
        force_evt = 1'b1;
        tick();
        sync_in = 1'b0;
        force_evt = 1'b0;
        chk("R9", "load over event cnt", int'(long_cnt), 13);
        chk("R9", "load over event pulse", int'(soc_pulse), 0);
        pulse_force();
        chk("R9", "count from init", int'(long_cnt), 14);
        pulse_force();
        chk("R9", "wrap from init pulse", int'(soc_pulse), 1);
        chk("R9", "wrap from init cnt", int'(long_cnt), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule